// File: doc/BRIEF.md
# Scrambled-Map Interrupt Controller with Per-Class Sense

This block gathers 63 active-low interrupt lines, indexed 1 to 63, into a single request to a processor. Each source owns one bit in a 32-bit "high" word and one in a 32-bit "low" word. The mapping from source number to word and bit is a fixed, non-linear table. Index 0 is reserved and has no line. For every source, the controller keeps a mask bit and a pending bit. Software reads and writes them through a small synchronous register bus that has word-select addressing.

Sources fall into three classes:

- **Internal sources** are level-sensitive and active-low.
- **External sources (19 to 25)** can each be set to level-low or to a latched falling edge.
- **Port sources (48 to 63)** always latch. Each one latches either on both edges or on the falling edge only.

A vector register holds the number of the lowest-numbered source that is both pending and unmasked. A single request line goes high whenever any such source exists. Software handles an interrupt in three steps: read the vector, service the source, then clear a latched pending bit by writing a one to it.

Top module: `irq_scramble_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both mask words and the sense register read zero. With all lines idle high, both pending words and the vector read zero and `irq_o` is low.
- R2: Each source maps to one word and one bit, as follows:
  - Sources 1..15 map to high-word bit 16-s.
  - Sources 16..18 map to low-word bit 18-s.
  - Sources 19..30 map to low-word bit 33-s.
  - Source 31 maps to low-word bit 15.
  - Sources 32..47 map to high-word bit 63-s.
  - Sources 48..63 map to low-word bit s-32.
  - High-word bit 0 always reads zero.
- R3: A mask bit of 1 enables its source and a mask bit of 0 blocks it. A blocked source still shows its pending bit, but it drives neither the vector nor `irq_o`.
- R4: Writing 1 to a pending bit clears a latched (edge) pending state. Writing 0 leaves the bit unchanged.
- R5: The vector register carries the lowest-numbered source that is pending and unmasked in bits 31:26, with bits 25:0 zero. It reads zero when no such source exists.
- R6: `irq_o` is high exactly when at least one pending bit has its mask bit set.
- R7: Internal sources (every source other than 19..25 and 48..63) read pending exactly while their synchronized line is low. Writing 1 to their pending bit has no lasting effect.
- R8: External source s (19..25) uses sense bit 33-s. A sense value of 1 latches pending on a falling edge, and the bit holds until it is cleared. A sense value of 0 makes the source level-low.
- R9: Port source s (48..63) uses sense bit s-32 and always latches. A sense value of 0 latches on both edges and a sense value of 1 latches on falling edges only.
- R10: Only sense bits 8..14 and 16..31 are storage. All other sense bits read zero.
- R11: The register addresses are:

  | Address | Register |
  |---------|----------|
  | 0 | mask high |
  | 1 | mask low |
  | 2 | pending high |
  | 3 | pending low |
  | 4 | sense |
  | 5 | vector (read-only) |

  Writes to addresses 5, 6 and 7 are ignored, and addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_n_i | input | 64 | Raw interrupt lines, bit s is source s, idle high; bit 0 unused |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register select |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected register, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The in-RTL properties assume the following about the inputs:

- A line seen by a cell holds steady for at least one cycle between edges. The edge and rise checks compare a line's value one cycle apart.
- A pending-clear write does not fall in the same cycle as an edge on that source.

The stimulus keeps within these limits by construction:

- It changes at most one source line at a time, on a falling clock edge, and then waits five cycles, which is longer than the two-stage synchronizer plus the edge register.
- It issues register writes only while the lines are quiet.

// File: rtl/irq_scr_pkg.sv
// Shared constants, register addresses and the source-to-bit mapping for the
// scrambled-map interrupt controller. Assumes 64 source indices and 32-bit words.
package irq_scr_pkg;

    localparam int SRC_CNT = 64;
    localparam int WORD_W  = 32;
    localparam int BIT_W   = $clog2(WORD_W);

    // Register addresses (word select)
    localparam int ADR_MASK_HI = 0;
    localparam int ADR_MASK_LO = 1;
    localparam int ADR_PEND_HI = 2;
    localparam int ADR_PEND_LO = 3;
    localparam int ADR_SENSE   = 4;
    localparam int ADR_VECTOR  = 5;

    // Sense bits that hold storage: external 8..14, port 16..31
    localparam logic [WORD_W-1:0] SENSE_WMASK = 32'hFFFF_7F00;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_INT  = 2'd1,
        CLS_EXT  = 2'd2,
        CLS_PORT = 2'd3
    } src_cls_e;

    // True when source s lives in the high word
    function automatic logic src_in_high(input int s);
        return (s <= 15) || (s >= 32 && s <= 47);
    endfunction

    // Bit position of source s inside its word
    function automatic int src_bit(input int s);
        if (s == 0)       return 0;
        else if (s <= 15) return 16 - s;
        else if (s <= 18) return 18 - s;
        else if (s <= 30) return 33 - s;
        else if (s == 31) return 15;
        else if (s <= 47) return 63 - s;
        else              return s - 32;
    endfunction

    // Sense class of source s
    function automatic src_cls_e src_class(input int s);
        if (s == 0)                return CLS_NONE;
        else if (s >= 19 && s <= 25) return CLS_EXT;
        else if (s >= 48)          return CLS_PORT;
        else                       return CLS_INT;
    endfunction

    // Sense-register bit used by source s (only meaningful for EXT and PORT)
    function automatic int sense_pos(input int s);
        if (s >= 19 && s <= 25) return 33 - s;
        else if (s >= 48)       return s - 32;
        else                    return 0;
    endfunction

endpackage

// File: rtl/irq_sync.sv
// Multi-stage synchronizer for a vector of asynchronous lines.
// Assumes each bit is independent; all stages reset to RST_VAL (idle level).
module irq_sync #(
    parameter int   WIDTH   = 64,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the raw lines through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= {WIDTH{RST_VAL}};
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_src_cell.sv
// One interrupt source: edge detector, pending latch and sense selection.
// Assumes lvl_i is already synchronous and active low. In level mode the pending
// output follows the line; in edge mode it shows the latch, which clears on clr_i.
// A detected edge wins over a simultaneous clear.
module irq_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic edge_mode_i,
    input  logic both_i,
    input  logic clr_i,
    output logic pend_o
);

    logic prev_q;
    logic latch_q;
    logic fall_hit;
    logic rise_hit;
    logic edge_hit;

    // Remember last cycle's line value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl_i;
    end

    // Decide whether this cycle carries an edge that should latch
    always_comb begin
        fall_hit = prev_q & ~lvl_i;
        rise_hit = ~prev_q & lvl_i;
        edge_hit = edge_mode_i & (fall_hit | (both_i & rise_hit));
    end

    // Pending latch: set on a qualifying edge, cleared by a one written to it
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= 1'b0;
        else if (edge_hit) latch_q <= 1'b1;
        else if (clr_i)    latch_q <= 1'b0;
    end

    // Present latch in edge mode, the live line in level mode
    assign pend_o = edge_mode_i ? latch_q : ~lvl_i;

    AST_FALL_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && $fell(lvl_i)) |=> latch_q); // R8
    AST_BOTH_RISE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && both_i && $rose(lvl_i)) |=> latch_q); // R9
    AST_FALL_ONLY_IGNORES_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && !both_i && $rose(lvl_i) && !latch_q) |=> !latch_q); // R9
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !clr_i) |=> latch_q); // R4

endmodule

// File: rtl/irq_prio_enc.sv
// Fixed-priority encoder: returns the index of the lowest set bit, or zero
// when no bit is set. Assumes the caller keeps bit 0 clear so zero means none.
module irq_prio_enc #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
)(
    input  logic [N-1:0]     elig_i,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top so the lowest set index is the final assignment
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_scramble_ctrl.sv
// Top of the scrambled-map interrupt controller. Synchronizes the source lines,
// runs one cell per source, folds pending/mask state into two register words
// through the fixed map, encodes the vector and drives the request line.
// Assumes a single-cycle write strobe and combinational read of the selected word.
module irq_scramble_ctrl
    import irq_scr_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_CNT-1:0] src_n_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [WORD_W-1:0]  bus_wdata_i,
    output logic [WORD_W-1:0]  bus_rdata_o,
    output logic               irq_o
);

    localparam int IDX_W   = $clog2(SRC_CNT);
    localparam int VEC_LSB = WORD_W - IDX_W;

    logic [SRC_CNT-1:0] src_sync;
    logic [WORD_W-1:0]  mask_hi, mask_lo, sense_q;
    logic [WORD_W-1:0]  clr_hi, clr_lo;
    logic [WORD_W-1:0]  pend_hi, pend_lo;
    wire  [SRC_CNT-1:0] src_pend;
    wire  [SRC_CNT-1:0] src_mask;
    logic [SRC_CNT-1:0] elig;
    logic [SRC_CNT-1:0] lower_m;
    logic [IDX_W-1:0]   vec_idx;

    irq_sync #(
        .WIDTH  (SRC_CNT),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (src_n_i),
        .q_o  (src_sync)
    );

    // Software-visible mask and sense storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_hi <= '0;
            mask_lo <= '0;
            sense_q <= '0;
        end else if (bus_wr_i) begin
            if (bus_addr_i == ADDR_W'(ADR_MASK_HI)) mask_hi <= bus_wdata_i;
            if (bus_addr_i == ADDR_W'(ADR_MASK_LO)) mask_lo <= bus_wdata_i;
            if (bus_addr_i == ADDR_W'(ADR_SENSE))   sense_q <= bus_wdata_i & SENSE_WMASK;
        end
    end

    // Write-one-to-clear strobes for each pending word
    always_comb begin
        clr_hi = (bus_wr_i && bus_addr_i == ADDR_W'(ADR_PEND_HI)) ? bus_wdata_i : '0;
        clr_lo = (bus_wr_i && bus_addr_i == ADDR_W'(ADR_PEND_LO)) ? bus_wdata_i : '0;
    end

    assign src_pend[0] = 1'b0;
    assign src_mask[0] = 1'b0;

    for (genvar s = 1; s < SRC_CNT; s++) begin : g_src
        localparam logic     HI  = src_in_high(s);
        localparam int       BP  = src_bit(s);
        localparam src_cls_e CLS = src_class(s);
        localparam int       SP  = sense_pos(s);
        logic edge_mode;
        logic both;
        logic clr;

        if (CLS == CLS_PORT) begin : g_port
            assign edge_mode = 1'b1;
            assign both      = ~sense_q[SP];
        end else if (CLS == CLS_EXT) begin : g_ext
            assign edge_mode = sense_q[SP];
            assign both      = 1'b0;
        end else begin : g_int
            assign edge_mode = 1'b0;
            assign both      = 1'b0;
        end

        assign clr         = HI ? clr_hi[BP]  : clr_lo[BP];
        assign src_mask[s] = HI ? mask_hi[BP] : mask_lo[BP];

        irq_src_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .lvl_i      (src_sync[s]),
            .edge_mode_i(edge_mode),
            .both_i     (both),
            .clr_i      (clr),
            .pend_o     (src_pend[s])
        );
    end

    // Fold per-source pending state into the two scrambled words
    always_comb begin
        pend_hi = '0;
        pend_lo = '0;
        for (int s = 1; s < SRC_CNT; s++) begin
            if (src_in_high(s)) pend_hi[BIT_W'(src_bit(s))] = src_pend[s];
            else                pend_lo[BIT_W'(src_bit(s))] = src_pend[s];
        end
    end

    // Eligible sources feed the fixed-priority encoder
    assign elig = src_pend & src_mask;

    irq_prio_enc #(
        .N    (SRC_CNT),
        .IDX_W(IDX_W)
    ) u_enc (
        .elig_i(elig),
        .idx_o (vec_idx)
    );

    // Request line from the register words
    assign irq_o = (|(pend_hi & mask_hi)) | (|(pend_lo & mask_lo));

    // Read-data select
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_W'(ADR_MASK_HI): bus_rdata_o = mask_hi;
            ADDR_W'(ADR_MASK_LO): bus_rdata_o = mask_lo;
            ADDR_W'(ADR_PEND_HI): bus_rdata_o = pend_hi;
            ADDR_W'(ADR_PEND_LO): bus_rdata_o = pend_lo;
            ADDR_W'(ADR_SENSE):   bus_rdata_o = sense_q;
            ADDR_W'(ADR_VECTOR):  bus_rdata_o = {vec_idx, {VEC_LSB{1'b0}}};
            default:              bus_rdata_o = '0;
        endcase
    end

    // Sources below the vector, used by the priority check
    always_comb lower_m = (SRC_CNT'(1) << vec_idx) - SRC_CNT'(1);

    AST_RESET_CLEARS_CFG: assert property (@(posedge clk)
        !rst_n |=> (mask_hi == '0 && mask_lo == '0 && sense_q == '0)); // R1
    AST_IRQ_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (vec_idx != '0)); // R6
    AST_VEC_IS_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_idx != '0) |-> (src_pend[vec_idx] && src_mask[vec_idx])); // R5
    AST_VEC_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (elig & lower_m) == '0); // R5
    AST_HI_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pend_hi[0] == 1'b0); // R2

endmodule

// File: tb/sim_irq_scramble_ctrl.sv
module sim_irq_scramble_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] pins;
    logic        wr;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    // Bench model
    logic [63:0] lat_m;
    logic [31:0] mhi_m, mlo_m, sen_m;

    always #10 clk = ~clk;

    irq_scramble_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_n_i    (pins),
        .bus_wr_i   (wr),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .irq_o      (irq)
    );

    function automatic bit m_hi(input int s);
        return (s >= 1 && s <= 15) || (s >= 32 && s <= 47);
    endfunction

    function automatic int m_bit(input int s);
        if (s <= 15) return 16 - s;
        if (s <= 18) return 18 - s;
        if (s <= 30) return 33 - s;
        if (s == 31) return 15;
        if (s <= 47) return 63 - s;
        return s - 32;
    endfunction

    // 0 internal, 1 external, 2 port
    function automatic int m_cls(input int s);
        if (s >= 19 && s <= 25) return 1;
        if (s >= 48) return 2;
        return 0;
    endfunction

    function automatic int m_sp(input int s);
        return (s >= 48) ? s - 32 : 33 - s;
    endfunction

    function automatic bit m_pend(input int s);
        if (s == 0) return 1'b0;
        if (m_cls(s) == 0) return !pins[s];
        if (m_cls(s) == 1 && !sen_m[m_sp(s)]) return !pins[s];
        return lat_m[s];
    endfunction

    function automatic bit m_mask(input int s);
        return m_hi(s) ? mhi_m[m_bit(s)] : mlo_m[m_bit(s)];
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        case (a)
            3'd0: mhi_m = d;
            3'd1: mlo_m = d;
            3'd4: sen_m = d & 32'hFFFF_7F00;
            3'd2, 3'd3: begin
                for (int s = 1; s < 64; s++)
                    if (m_hi(s) == (a == 3'd2) && d[m_bit(s)]) lat_m[s] = 1'b0;
            end
            default: ;
        endcase
    endtask

    task automatic drive_pin(input int s, input bit v);
        bit old;
        old = pins[s];
        @(negedge clk);
        pins[s] = v;
        if (m_cls(s) == 2) begin
            if (old && !v) lat_m[s] = 1'b1;
            if (!old && v && !sen_m[m_sp(s)]) lat_m[s] = 1'b1;
        end else if (m_cls(s) == 1 && sen_m[m_sp(s)] && old && !v) begin
            lat_m[s] = 1'b1;
        end
        repeat (5) @(posedge clk);
    endtask

    task automatic check_all(input string ctx);
        logic [31:0] eh, el, ev, d;
        eh = '0; el = '0; ev = '0;
        for (int s = 63; s >= 1; s--) begin
            if (m_hi(s)) eh[m_bit(s)] = m_pend(s);
            else         el[m_bit(s)] = m_pend(s);
            if (m_pend(s) && m_mask(s)) ev = 32'(s) << 26;
        end
        rd(3'd0, d); chk("R3", {ctx, " mask_hi"}, d, mhi_m);
        rd(3'd1, d); chk("R3", {ctx, " mask_lo"}, d, mlo_m);
        rd(3'd2, d); chk("R2", {ctx, " pend_hi"}, d, eh);
        rd(3'd3, d); chk("R2", {ctx, " pend_lo"}, d, el);
        rd(3'd4, d); chk("R10", {ctx, " sense"}, d, sen_m);
        rd(3'd5, d); chk("R5", {ctx, " vector"}, d, ev);
        chk("R6", {ctx, " irq"}, {31'b0, irq}, {31'b0, ev != 0});
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; pins = '1; wr = 1'b0; addr = '0; wdata = '0;
        lat_m = '0; mhi_m = '0; mlo_m = '0; sen_m = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d); chk("R1", "reset register", d, 32'h0);
        end
        chk("R1", "reset irq", {31'b0, irq}, 32'h0);

        // R10 sense storage positions
        wr_reg(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d); chk("R10", "sense storage bits", d, 32'hFFFF_7F00);
        wr_reg(3'd4, 32'h0);

        // R11 ignored addresses
        wr_reg(3'd5, 32'hFFFF_FFFF);
        wr_reg(3'd6, 32'hFFFF_FFFF);
        wr_reg(3'd7, 32'hFFFF_FFFF);
        rd(3'd5, d); chk("R11", "vector after write", d, 32'h0);
        rd(3'd6, d); chk("R11", "addr6 read", d, 32'h0);
        rd(3'd7, d); chk("R11", "addr7 read", d, 32'h0);
        rd(3'd0, d); chk("R11", "mask_hi untouched", d, 32'h0);

        // R2 every source lands on its mapped bit; R5/R6 follow
        wr_reg(3'd0, 32'hFFFF_FFFF);
        wr_reg(3'd1, 32'hFFFF_FFFF);
        for (int s = 1; s < 64; s++) begin
            drive_pin(s, 1'b0);
            rd(m_hi(s) ? 3'd2 : 3'd3, d);
            chk("R2", $sformatf("src %0d bit", s), d, 32'h1 << m_bit(s));
            rd(m_hi(s) ? 3'd3 : 3'd2, d);
            chk("R2", $sformatf("src %0d other word", s), d, 32'h0);
            rd(3'd5, d);
            chk("R5", $sformatf("src %0d vector", s), d, 32'(s) << 26);
            chk("R6", $sformatf("src %0d irq", s), {31'b0, irq}, 32'h1);
            drive_pin(s, 1'b1);
            wr_reg(3'd2, 32'hFFFF_FFFF);
            wr_reg(3'd3, 32'hFFFF_FFFF);
        end
        check_all("after map sweep");

        // R3 masked source visible but silent
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd1, 32'h0);
        drive_pin(5, 1'b0);
        rd(3'd2, d); chk("R3", "masked pending visible", d, 32'h0000_0800);
        rd(3'd5, d); chk("R3", "masked vector", d, 32'h0);
        chk("R3", "masked irq", {31'b0, irq}, 32'h0);
        wr_reg(3'd0, 32'h0000_0800);
        rd(3'd5, d); chk("R3", "unmasked vector", d, 32'd5 << 26);
        drive_pin(5, 1'b1);

        // R7 internal level source ignores clear
        wr_reg(3'd0, 32'hFFFF_FFFF);
        wr_reg(3'd1, 32'hFFFF_FFFF);
        drive_pin(40, 1'b0);
        wr_reg(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, d); chk("R7", "internal held after clear", d, 32'h0080_0000);
        drive_pin(40, 1'b1);
        rd(3'd2, d); chk("R7", "internal released", d, 32'h0);

        // R8 external source 20 in edge mode (sense bit 13)
        wr_reg(3'd4, 32'h0000_2000);
        drive_pin(20, 1'b0);
        drive_pin(20, 1'b1);
        rd(3'd3, d); chk("R8", "ext latched after release", d, 32'h0000_2000);
        wr_reg(3'd4, 32'h0);
        rd(3'd3, d); chk("R8", "ext level mode idle", d, 32'h0);
        wr_reg(3'd3, 32'h0000_2000);

        // R9 port source 50 (sense bit 18): falling only, then both
        wr_reg(3'd4, 32'h0004_0000);
        drive_pin(50, 1'b0);
        rd(3'd3, d); chk("R9", "port fall latched", d, 32'h0004_0000);
        wr_reg(3'd3, 32'h0004_0000);
        drive_pin(50, 1'b1);
        rd(3'd3, d); chk("R9", "port rise ignored", d, 32'h0);
        wr_reg(3'd4, 32'h0);
        drive_pin(50, 1'b0);
        wr_reg(3'd3, 32'h0004_0000);
        drive_pin(50, 1'b1);
        rd(3'd3, d); chk("R9", "port rise latched", d, 32'h0004_0000);
        wr_reg(3'd3, 32'h0004_0000);

        // R4 zero writes keep, one writes clear (port 55, low bit 23)
        drive_pin(55, 1'b0);
        wr_reg(3'd3, 32'h0);
        rd(3'd3, d); chk("R4", "zero write keeps", d, 32'h0080_0000);
        wr_reg(3'd3, 32'h0080_0000);
        rd(3'd3, d); chk("R4", "one write clears", d, 32'h0);
        drive_pin(55, 1'b1);
        wr_reg(3'd3, 32'hFFFF_FFFF);

        // R5 priority between two sources
        drive_pin(40, 1'b0);
        drive_pin(10, 1'b0);
        rd(3'd5, d); chk("R5", "lowest wins", d, 32'd10 << 26);
        wr_reg(3'd0, 32'hFFFF_FFBF);
        rd(3'd5, d); chk("R5", "next after mask", d, 32'd40 << 26);
        drive_pin(40, 1'b1);
        drive_pin(10, 1'b1);
        check_all("after directed");

        // Random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op <= 4) begin
                int s;
                s = $urandom_range(1, 63);
                drive_pin(s, !pins[s]);
            end else if (op <= 6) begin
                wr_reg(3'(op - 5), $urandom());
            end else if (op == 7) begin
                wr_reg(3'd4, $urandom());
            end else begin
                wr_reg(3'(op - 6), $urandom());
            end
            check_all($sformatf("random %0d", it));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule